// File: doc/BRIEF.md
# Packet Command Sequencer for an Optical Drive Tray

This block drives an optical drive over the parallel task-file interface to run one complete packet command, or two chained ones, without processor help. It issues single register accesses to a register access engine below it, with a request/acknowledge handshake. That engine owns the chip-select and strobe timing.

A start request launches a run. The run opens with a hardware reset pulse on the drive's reset line, followed by a long settle wait. The block then writes four configuration registers. For each command it:

- polls status until the drive is idle,
- writes the packet opcode,
- polls until the drive asks for the packet,
- writes the 12-byte packet as six 16-bit words,
- waits for the drive's interrupt line, then reads status once.

A two-bit selector picks between tray unlock, tray eject, or unlock followed by eject. The block ends each run with a one-cycle done pulse and an error flag. The flag is set on a wait that takes too long or on a completion status with the check bit set.

Top module: `atapi_pkt_seq`

## Requirements
- R1: On an accepted start, `dev_rst_no` goes low for exactly `RST_LOW_CYC` cycles. It then stays high for exactly `RST_WAIT_CYC` cycles before the first access request. No request is made while it is low.
- R2: The first four accesses of a run are writes, in this order: register 6 (device select) with 0x0000, register 1 (features) with 0x0000, register 4 (byte count low) with 0x00FF, and register 5 (byte count high) with 0x00FF.
- R3: Before each command, status (register 7) is read repeatedly until bit 7 (busy) and bit 3 (data request) are both clear. Then register 7 is written with 0x00A0.
- R4: After the 0x00A0 write, status is read repeatedly until bit 7 is clear and bit 3 is set. Any other value causes another read.
- R5: The packet is six writes to register 0, in order. Word k carries packet byte 2k in bits 7:0 and byte 2k+1 in bits 15:8. For unlock, word 0 is 0x001E and all other words are zero. For eject, word 0 is 0x001B, word 2 is 0x0002 and all other words are zero.
- R6: After the sixth word, no access is requested until `intrq_i` is high. Exactly one status read follows. If bit 0 (check) of that read is set, the run ends with an error.
- R7: `pkt_sel_i`, sampled at start, selects the commands. Value 0 runs unlock only, value 1 runs eject only, and values 2 and 3 run unlock then eject. A fresh idle poll (R3) runs between the two commands.
- R8: A status poll or interrupt wait that has lasted `POLL_TO` cycles ends the run with an error. The timeout takes effect at the next failing status read, or at once for the interrupt wait. An error stops any remaining chained command.
- R9: `done_o` is a single-cycle pulse at the end of each run. `err_o` may be high only together with `done_o`.
- R10: While `req_o` is high and `ack_i` is low, `req_o`, `we_o`, `reg_addr_o` and `wdata_o` hold their values.
- R11: `start_i` has no effect while a run is in progress. Each run produces a single reset pulse and a single done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a run when idle |
| pkt_sel_i | input | 2 | Command selector (R7) |
| dev_rst_no | output | 1 | Drive hardware reset line, active low |
| req_o | output | 1 | Register access request |
| we_o | output | 1 | 1 = write, 0 = read |
| reg_addr_o | output | 3 | Task-file register index |
| wdata_o | output | 16 | Write data |
| ack_i | input | 1 | Access complete, one cycle |
| rdata_i | input | 8 | Status byte returned with `ack_i` on reads |
| intrq_i | input | 1 | Drive interrupt request |
| done_o | output | 1 | Run finished, one-cycle pulse |
| err_o | output | 1 | Run ended in error, valid with `done_o` |

## Verification
The bench builds the block with `RST_LOW_CYC` = 8, `RST_WAIT_CYC` = 12 and `POLL_TO` = 40. With these values the reset pulse and settle wait can be measured exactly, cycle by cycle. A drive that stays busy forever then reaches the poll timeout within a few dozen cycles, so a timeout run costs little simulation time.

A behavioural drive model answers the status reads in several ways:
- busy,
- data request still set,
- busy clear but data request clear.

With these answers the bench exercises every poll-retry branch, the check-bit error, a missing interrupt, and all selector values, in a few thousand cycles.

// File: rtl/atapi_seq_pkg.sv
package atapi_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_RST_LO, S_RST_WAIT, S_W_DEV, S_W_FEAT, S_W_BCL, S_W_BCH,
    S_POLL_IDLE, S_W_CMD, S_POLL_DRQ, S_W_PKT, S_WAIT_INT, S_R_FINAL, S_FIN
  } seq_state_e;

  typedef enum logic {PKT_UNLOCK = 1'b0, PKT_EJECT = 1'b1} pkt_kind_e;

  // task-file register indices decoded by the access engine
  localparam logic [2:0] REG_DATA  = 3'd0;
  localparam logic [2:0] REG_FEAT  = 3'd1;
  localparam logic [2:0] REG_BCL   = 3'd4;
  localparam logic [2:0] REG_BCH   = 3'd5;
  localparam logic [2:0] REG_DEV   = 3'd6;
  localparam logic [2:0] REG_STCMD = 3'd7;

  localparam int unsigned ST_BSY = 7;
  localparam int unsigned ST_DRQ = 3;
  localparam int unsigned ST_CHK = 0;

  localparam logic [7:0] OP_PACKET  = 8'hA0;
  localparam logic [7:0] OP_UNLOCK  = 8'h1E;
  localparam logic [7:0] OP_EJECT   = 8'h1B;
  localparam int unsigned EJ_ARG_POS = 4;
  localparam logic [7:0] EJ_ARG_VAL = 8'h02;
  localparam logic [15:0] BCOUNT_FILL = 16'h00FF;

  function automatic logic [7:0] pkt_byte(pkt_kind_e k, int unsigned n);
    if (n == 0) return (k == PKT_EJECT) ? OP_EJECT : OP_UNLOCK;
    if (k == PKT_EJECT && n == EJ_ARG_POS) return EJ_ARG_VAL;
    return 8'h00;
  endfunction

endpackage

// File: rtl/atapi_wait_timer.sv
module atapi_wait_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - TW'(1);
  end

  assign zero_o = (cnt_q == '0);

  // R8: an expired window stays expired until reloaded
  p_timer_zero_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/atapi_pkt_words.sv
module atapi_pkt_words
  import atapi_seq_pkg::*;
#(
  parameter int unsigned WORDS = 6,
  parameter int unsigned IW    = 3
) (
  input  pkt_kind_e     kind_i,
  input  logic [IW-1:0] idx_i,
  output logic [15:0]   word_o
);
  logic [15:0] unl_w [WORDS];
  logic [15:0] ej_w  [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign unl_w[w] = {pkt_byte(PKT_UNLOCK, 2*w+1), pkt_byte(PKT_UNLOCK, 2*w)};
    assign ej_w[w]  = {pkt_byte(PKT_EJECT,  2*w+1), pkt_byte(PKT_EJECT,  2*w)};
  end

  always_comb begin
    word_o = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (int'(idx_i) == i) word_o = (kind_i == PKT_EJECT) ? ej_w[i] : unl_w[i];
    end
  end

endmodule

// File: rtl/atapi_seq_ctrl.sv
module atapi_seq_ctrl
  import atapi_seq_pkg::*;
#(
  parameter int unsigned TW           = 8,
  parameter int unsigned RST_LOW_CYC  = 8,
  parameter int unsigned RST_WAIT_CYC = 8,
  parameter int unsigned POLL_TO      = 8,
  parameter int unsigned WORDS        = 6,
  parameter int unsigned IW           = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    pkt_sel_i,
  input  logic          ack_i,
  input  logic [7:0]    rdata_i,
  input  logic          intrq_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output pkt_kind_e     kind_o,
  output logic [IW-1:0] idx_o,
  input  logic [15:0]   pkt_word_i,
  output logic          req_o,
  output logic          we_o,
  output logic [2:0]    reg_addr_o,
  output logic [15:0]   wdata_o,
  output logic          dev_rst_no,
  output logic          done_o,
  output logic          err_o
);
  seq_state_e    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  pkt_kind_e     kind_q, kind_d;
  logic          chain_q, chain_d;
  logic          err_q, err_d;

  wire st_idle = !rdata_i[ST_BSY] && !rdata_i[ST_DRQ];
  wire st_drq  = !rdata_i[ST_BSY] &&  rdata_i[ST_DRQ];

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    kind_d     = kind_q;
    chain_d    = chain_q;
    err_d      = err_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d    = S_RST_LO;
        kind_d     = (pkt_sel_i == 2'd1) ? PKT_EJECT : PKT_UNLOCK;
        chain_d    = pkt_sel_i[1];
        err_d      = 1'b0;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(RST_LOW_CYC - 1);
      end
      S_RST_LO: if (tmr_zero_i) begin
        state_d    = S_RST_WAIT;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(RST_WAIT_CYC - 1);
      end
      S_RST_WAIT: if (tmr_zero_i) state_d = S_W_DEV;
      S_W_DEV:    if (ack_i) state_d = S_W_FEAT;
      S_W_FEAT:   if (ack_i) state_d = S_W_BCL;
      S_W_BCL:    if (ack_i) state_d = S_W_BCH;
      S_W_BCH: if (ack_i) begin
        state_d    = S_POLL_IDLE;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(POLL_TO - 1);
      end
      S_POLL_IDLE: if (ack_i) begin
        if (st_idle) state_d = S_W_CMD;
        else if (tmr_zero_i) begin state_d = S_FIN; err_d = 1'b1; end
      end
      S_W_CMD: if (ack_i) begin
        state_d    = S_POLL_DRQ;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(POLL_TO - 1);
      end
      S_POLL_DRQ: if (ack_i) begin
        if (st_drq) begin state_d = S_W_PKT; idx_d = '0; end
        else if (tmr_zero_i) begin state_d = S_FIN; err_d = 1'b1; end
      end
      S_W_PKT: if (ack_i) begin
        if (idx_q == IW'(WORDS - 1)) begin
          state_d    = S_WAIT_INT;
          tmr_load_o = 1'b1;
          tmr_val_o  = TW'(POLL_TO - 1);
        end else idx_d = idx_q + IW'(1);
      end
      S_WAIT_INT: begin
        if (intrq_i) state_d = S_R_FINAL;
        else if (tmr_zero_i) begin state_d = S_FIN; err_d = 1'b1; end
      end
      S_R_FINAL: if (ack_i) begin
        if (rdata_i[ST_CHK]) begin state_d = S_FIN; err_d = 1'b1; end
        else if (chain_q) begin
          chain_d    = 1'b0;
          kind_d     = PKT_EJECT;
          state_d    = S_POLL_IDLE;
          tmr_load_o = 1'b1;
          tmr_val_o  = TW'(POLL_TO - 1);
        end else state_d = S_FIN;
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      kind_q  <= PKT_UNLOCK;
      chain_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      kind_q  <= kind_d;
      chain_q <= chain_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    req_o      = 1'b1;
    we_o       = 1'b1;
    reg_addr_o = REG_STCMD;
    wdata_o    = '0;
    unique case (state_q)
      S_W_DEV:     reg_addr_o = REG_DEV;
      S_W_FEAT:    reg_addr_o = REG_FEAT;
      S_W_BCL:     begin reg_addr_o = REG_BCL; wdata_o = BCOUNT_FILL; end
      S_W_BCH:     begin reg_addr_o = REG_BCH; wdata_o = BCOUNT_FILL; end
      S_W_CMD:     wdata_o = {8'h00, OP_PACKET};
      S_W_PKT:     begin reg_addr_o = REG_DATA; wdata_o = pkt_word_i; end
      S_POLL_IDLE, S_POLL_DRQ, S_R_FINAL: we_o = 1'b0;
      default:     begin req_o = 1'b0; we_o = 1'b0; end
    endcase
  end

  assign kind_o     = kind_q;
  assign idx_o      = idx_q;
  assign dev_rst_no = (state_q != S_RST_LO);
  assign done_o     = (state_q == S_FIN);
  assign err_o      = done_o && err_q;

  p_no_req_at_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dev_rst_no) |-> !req_o);

  p_cmd_after_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == S_POLL_IDLE && state_q == S_W_CMD) |->
      (!$past(rdata_i[ST_BSY]) && !$past(rdata_i[ST_DRQ])));

  p_pkt_after_drq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == S_POLL_DRQ && state_q == S_W_PKT) |->
      (!$past(rdata_i[ST_BSY]) && $past(rdata_i[ST_DRQ])));

  p_check_bit_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_R_FINAL && ack_i && rdata_i[ST_CHK]) |=> (done_o && err_o));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_err_with_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(we_o) && $stable(reg_addr_o) && $stable(wdata_o)));

endmodule

// File: rtl/atapi_pkt_seq.sv
module atapi_pkt_seq
  import atapi_seq_pkg::*;
#(
  parameter int unsigned RST_LOW_CYC  = 20_000_000,
  parameter int unsigned RST_WAIT_CYC = 200_000_000,
  parameter int unsigned POLL_TO      = 1_000_000,
  parameter int unsigned PKT_WORDS    = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [1:0]  pkt_sel_i,
  output logic        dev_rst_no,
  output logic        req_o,
  output logic        we_o,
  output logic [2:0]  reg_addr_o,
  output logic [15:0] wdata_o,
  input  logic        ack_i,
  input  logic [7:0]  rdata_i,
  input  logic        intrq_i,
  output logic        done_o,
  output logic        err_o
);
  localparam int unsigned MAX_AB = (RST_LOW_CYC > RST_WAIT_CYC) ? RST_LOW_CYC : RST_WAIT_CYC;
  localparam int unsigned MAX_C  = (MAX_AB > POLL_TO) ? MAX_AB : POLL_TO;
  localparam int unsigned TW     = $clog2(MAX_C + 1);
  localparam int unsigned IW     = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1;

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  pkt_kind_e     kind;
  logic [IW-1:0] idx;
  logic [15:0]   pkt_word;

  atapi_wait_timer #(.TW(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  atapi_pkt_words #(.WORDS(PKT_WORDS), .IW(IW)) u_words (
    .kind_i (kind),
    .idx_i  (idx),
    .word_o (pkt_word)
  );

  atapi_seq_ctrl #(
    .TW(TW), .RST_LOW_CYC(RST_LOW_CYC), .RST_WAIT_CYC(RST_WAIT_CYC),
    .POLL_TO(POLL_TO), .WORDS(PKT_WORDS), .IW(IW)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .pkt_sel_i  (pkt_sel_i),
    .ack_i      (ack_i),
    .rdata_i    (rdata_i),
    .intrq_i    (intrq_i),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .kind_o     (kind),
    .idx_o      (idx),
    .pkt_word_i (pkt_word),
    .req_o      (req_o),
    .we_o       (we_o),
    .reg_addr_o (reg_addr_o),
    .wdata_o    (wdata_o),
    .dev_rst_no (dev_rst_no),
    .done_o     (done_o),
    .err_o      (err_o)
  );

endmodule

// File: tb/sim_atapi_pkt_seq.sv
module sim_atapi_pkt_seq;
  localparam int RST_LOW = 8, RST_WAIT = 12, POLL_TO = 40, LAT = 2, INT_DLY = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic start = 1'b0;
  logic [1:0] sel = 2'd0;
  logic dev_rst_n, req, we, done, err;
  logic [2:0] addr;
  logic [15:0] wd;
  logic ack = 1'b0, intrq = 1'b0;
  logic [7:0] rdata = 8'h00;

  atapi_pkt_seq #(.RST_LOW_CYC(RST_LOW), .RST_WAIT_CYC(RST_WAIT), .POLL_TO(POLL_TO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pkt_sel_i(sel),
    .dev_rst_no(dev_rst_n), .req_o(req), .we_o(we), .reg_addr_o(addr),
    .wdata_o(wd), .ack_i(ack), .rdata_i(rdata), .intrq_i(intrq),
    .done_o(done), .err_o(err));

  int errors = 0, checks = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // expected access log: {we, addr, data}
  logic [19:0] exp_q[$];
  string tag_q[$];
  task automatic push(input bit w, input logic [2:0] a, input logic [15:0] d, input string t);
    exp_q.push_back({w, a, d});
    tag_q.push_back(t);
  endtask

  // drive model configuration and state
  int pre_busy, pre_drq, drq_cfg, drq_left, dwords, int_cnt, phase;
  bit chk_cfg, stuck, no_int;
  int cyc = 0, t_setup = 0, lat_cnt = 0;
  int low_cnt = 0, hi_cnt = 0, falls = 0;
  bit meas_hi = 0;
  logic prev_req = 0, prev_ack = 0, prev_we = 0, prev_rst = 1;
  logic [2:0] prev_addr = 0;
  logic [15:0] prev_wd = 0;

  task automatic serve();
    logic [19:0] got, e;
    string t;
    got = {we, addr, we ? wd : 16'h0000};
    if (!we) begin
      if (phase == 2) begin
        rdata = chk_cfg ? 8'h41 : 8'h40;
        intrq = 1'b0;
        phase = 0;
      end else if (phase == 1) begin
        if (drq_left > 0) begin
          rdata = (drq_left % 2 == 1) ? 8'h80 : 8'h40;
          drq_left--;
        end else rdata = 8'h48;
      end else if (stuck) rdata = 8'h80;
      else if (pre_busy > 0) begin rdata = 8'h80; pre_busy--; end
      else if (pre_drq > 0) begin rdata = 8'h48; pre_drq--; end
      else rdata = 8'h40;
    end
    if (!we && stuck) chk(addr == 3'd7, "R3", "poll address", addr, 7);
    else if (exp_q.size() == 0) chk(0, "R2", "unexpected access", got, 0);
    else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(got == e, t, "access {we,addr,data}", got, e);
    end
    if (we) begin
      if (addr == 3'd5) t_setup = cyc;
      if (addr == 3'd7 && wd == 16'h00A0) begin
        phase = 1; drq_left = drq_cfg; dwords = 0;
      end else if (addr == 3'd0 && phase == 1) begin
        dwords++;
        if (dwords == 6) begin phase = 2; int_cnt = INT_DLY; end
      end
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_req && !prev_ack)
        chk(req && we == prev_we && addr == prev_addr && wd == prev_wd,
            "R10", "held request", {req, we, addr, wd}, {1'b1, prev_we, prev_addr, prev_wd});
      if (!dev_rst_n) begin
        low_cnt++;
        if (prev_rst) falls++;
        if (req) chk(0, "R1", "request while reset low", req, 0);
      end else if (low_cnt > 0) begin
        chk(low_cnt == RST_LOW, "R1", "reset low cycles", low_cnt, RST_LOW);
        low_cnt = 0; meas_hi = 1; hi_cnt = 0;
      end
      if (meas_hi) begin
        if (req) begin
          chk(hi_cnt == RST_WAIT, "R1", "settle cycles", hi_cnt, RST_WAIT);
          meas_hi = 0;
        end else hi_cnt++;
      end
      if (phase == 2 && !intrq && req) chk(0, "R6", "access before interrupt", req, 0);
      if (done && !err && exp_q.size() != 0) chk(0, "R9", "done before sequence end", exp_q.size(), 0);
    end
    if (ack) ack = 1'b0;
    else if (req) begin
      if (lat_cnt >= LAT) begin ack = 1'b1; lat_cnt = 0; serve(); end
      else lat_cnt++;
    end else lat_cnt = 0;
    if (phase == 2 && !no_int && !intrq) begin
      if (int_cnt > 0) int_cnt--;
      if (int_cnt == 0) intrq = 1'b1;
    end
    prev_req = req; prev_ack = ack; prev_we = we; prev_addr = addr; prev_wd = wd;
    prev_rst = dev_rst_n;
  end

  task automatic build(input int s, input int pb, input int pd, input int db,
                       input bit ck, input bit st, input bit ni);
    int npk;
    bit ej;
    exp_q.delete(); tag_q.delete();
    push(1, 3'd6, 16'h0000, "R2");
    push(1, 3'd1, 16'h0000, "R2");
    push(1, 3'd4, 16'h00FF, "R2");
    push(1, 3'd5, 16'h00FF, "R2");
    if (st) return;
    npk = (s >= 2) ? 2 : 1;
    for (int p = 0; p < npk; p++) begin
      ej = (s == 1) || (p == 1);
      for (int i = 0; i < ((p == 0) ? pb + pd + 1 : 1); i++) push(0, 3'd7, 16'h0, (p == 1) ? "R7" : "R3");
      push(1, 3'd7, 16'h00A0, "R3");
      for (int i = 0; i < db + 1; i++) push(0, 3'd7, 16'h0, "R4");
      push(1, 3'd0, ej ? 16'h001B : 16'h001E, "R5");
      push(1, 3'd0, 16'h0000, "R5");
      push(1, 3'd0, ej ? 16'h0002 : 16'h0000, "R5");
      for (int i = 0; i < 3; i++) push(1, 3'd0, 16'h0000, "R5");
      if (ni) return;
      push(0, 3'd7, 16'h0, "R6");
      if (ck) return;
    end
  endtask

  task automatic run(input int s, input int pb, input int pd, input int db, input bit ck,
                     input bit st, input bit ni, input bit exp_err, input bit restart,
                     input string rq);
    int n;
    pre_busy = pb; pre_drq = pd; drq_cfg = db; chk_cfg = ck; stuck = st; no_int = ni;
    phase = 0; intrq = 1'b0; falls = 0;
    build(s, pb, pd, db, ck, st, ni);
    @(negedge clk); start = 1'b1; sel = 2'(s);
    @(negedge clk); start = 1'b0; sel = 2'(3 - s);
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
      if (restart && n == 60) begin start = 1'b1; sel = 2'd1; end
      if (restart && n == 62) start = 1'b0;
    end
    if (!done) chk(0, rq, "watchdog: no done", 0, 1);
    else begin
      chk(err == exp_err, rq, "error flag", err, exp_err);
      if (st) chk(cyc - t_setup >= POLL_TO - 2 && cyc - t_setup <= POLL_TO + LAT + 6,
                  "R8", "timeout latency", cyc - t_setup, POLL_TO);
    end
    chk(exp_q.size() == 0, rq, "missing accesses", exp_q.size(), 0);
    chk(falls == 1, "R11", "reset pulses per run", falls, 1);
    @(negedge clk);
    chk(!done && !err, "R9", "done is one cycle", {done, err}, 0);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(dev_rst_n == 1'b1 && !req && !done && !err, "R9", "reset state",
        {dev_rst_n, req, done, err}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!req && dev_rst_n, "R1", "idle after reset", {req, dev_rst_n}, 2'b01);
    run(0, 2, 1, 2, 0, 0, 0, 0, 0, "R5");
    run(1, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
    run(2, 1, 0, 3, 0, 0, 0, 0, 1, "R11");
    run(2, 0, 2, 1, 1, 0, 0, 1, 0, "R6");
    run(0, 0, 0, 0, 0, 1, 0, 1, 0, "R8");
    run(1, 0, 0, 0, 0, 0, 1, 1, 0, "R8");
    run(3, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R9 global watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule